// File: doc/BRIEF.md
# Fetch Next-PC Predictor with Two-Bit Branch Table

This block chooses the next instruction fetch address in the first stage of a three-stage RV32 pipeline. The stages are fetch, decode/execute and writeback. Each fetched 32-bit word is pre-decoded only far enough to find an unconditional jump-and-link or a conditional branch, and to form its PC-relative target. A jump-and-link always redirects fetch to its target. A conditional branch redirects only when its two-bit counter in a direct-mapped history table says taken. Every other word falls through to PC+4.

The predicted-taken bit and the predicted next address leave the block with the instruction. When the instruction reaches writeback, the pipeline returns the resolved branch outcome. A correction unit in this block then trains the counter for that branch. If the outcome differs from the prediction, the correction unit raises a pipeline-wide flush and supplies the correct fetch address, and that address overrides any prediction made in the same cycle.

Each counter is a four-state machine: STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). A taken outcome moves a counter one state toward STRONG_T, and STRONG_T stays put on taken. A not-taken outcome moves a counter one state toward STRONG_NT, and STRONG_NT stays put on not-taken. The next-PC selector has four named choices: SEL_FLUSH, SEL_JUMP, SEL_BRANCH and SEL_SEQ. They are picked in that priority order.

Top module: `fetch_nextpc_predictor`

## Requirements
- R1: After reset every counter is WEAK_NT (01), so any conditional branch fetched before training is predicted not-taken and next_pc is fetch_pc+4.
- R2: A valid fetch word with opcode bits [6:0] = 1101111 (jump-and-link) is always predicted taken. Its target is fetch_pc plus the J-type immediate, whatever the table holds.
- R3: A valid fetch word with opcode 1100011 and funct3 bits [14:12] in {000, 001, 100, 101, 110, 111} is predicted taken exactly when its counter is 10 or 11. The target is then fetch_pc plus the B-type immediate.
- R4: When fetch_valid is low, or the word is neither of the above (including opcode 1100011 with funct3 010 or 011), pred_taken is 0 and pred_target is fetch_pc+4.
- R5: A writeback report (wb_valid high) steps the addressed counter up on taken and down on not-taken. It saturates at 11 and 00. No counter changes when wb_valid is low.
- R6: The table has 2^IDX_BITS entries (64 by default), selected by PC bits [IDX_BITS+1:2]. Two branches with equal index bits share a counter.
- R7: When wb_valid is high and wb_taken differs from wb_pred_taken, flush is asserted in the same cycle. flush_pc is wb_target if the branch was actually taken, and wb_pc+4 otherwise.
- R8: In a flush cycle next_pc equals flush_pc, regardless of the prediction. Outside a flush next_pc equals pred_target.
- R9: A counter updated at a clock edge affects predictions only from the following cycle. A fetch that reads the entry in the update cycle sees the old value.
- R10: flush stays low when wb_valid is low or when the resolved outcome matches the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | fetch_insn holds a fetched word |
| fetch_pc | input | 32 | Address of the fetched word |
| fetch_insn | input | 32 | Fetched instruction word |
| pred_taken | output | 1 | Fetch-time taken prediction, travels with the instruction |
| pred_target | output | 32 | Predicted next address (target or PC+4), travels with the instruction |
| next_pc | output | 32 | Address to fetch next |
| wb_valid | input | 1 | A resolved conditional branch is in writeback |
| wb_pc | input | 32 | Address of the resolved branch |
| wb_taken | input | 1 | Actual branch outcome |
| wb_pred_taken | input | 1 | Prediction that was made for it at fetch |
| wb_target | input | 32 | Branch target computed for it |
| flush | output | 1 | Mispredict: flush the pipeline |
| flush_pc | output | 32 | Correct fetch address during a flush |

## Verification
Fetch prediction and writeback correction can act in the same cycle in two ways. First, a flush can coincide with a fetched jump-and-link or a trained taken branch; there, next_pc must follow flush_pc and ignore the prediction. Second, writeback can train the very counter that the fetched branch is reading; there, the prediction must reflect the pre-update state, and the updated value must appear one cycle later. Directed steps place both collisions on purpose, and a random phase draws fetch and writeback PCs from a small aliasing window so that both recur. In both cases a behavioural counter array in the bench predicts every output, and the outputs are compared every cycle.

// File: rtl/nxpc_pkg.sv
`timescale 1ns/1ps
package nxpc_pkg;

    localparam int XLEN = 32;

    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    typedef enum logic [1:0] {
        STRONG_NT = 2'b00,
        WEAK_NT   = 2'b01,
        WEAK_T    = 2'b10,
        STRONG_T  = 2'b11
    } ctr_state_e;

    typedef enum logic [1:0] {
        SEL_SEQ,
        SEL_BRANCH,
        SEL_JUMP,
        SEL_FLUSH
    } pc_sel_e;

    // One training step of a saturating counter.
    function automatic ctr_state_e ctr_step(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            STRONG_NT: nxt = taken ? WEAK_NT  : STRONG_NT;
            WEAK_NT:   nxt = taken ? WEAK_T   : STRONG_NT;
            WEAK_T:    nxt = taken ? STRONG_T : WEAK_NT;
            STRONG_T:  nxt = taken ? STRONG_T : WEAK_T;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_state_e cur);
        return (cur == WEAK_T) || (cur == STRONG_T);
    endfunction

endpackage

// File: rtl/nxpc_predecode.sv
`timescale 1ns/1ps
module nxpc_predecode
    import nxpc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [31:0]     insn,
    output logic            is_jump,
    output logic            is_cond,
    output logic [XLEN-1:0] jump_tgt,
    output logic [XLEN-1:0] cond_tgt
);

    logic [XLEN-1:0] imm_j;
    logic [XLEN-1:0] imm_b;
    logic [2:0]      f3;

    assign f3 = insn[14:12];

    always_comb begin
        imm_j = {{(XLEN-20){insn[31]}}, insn[19:12], insn[20], insn[30:21], 1'b0};
        imm_b = {{(XLEN-12){insn[31]}}, insn[7], insn[30:25], insn[11:8], 1'b0};
    end

    always_comb begin
        is_jump = (insn[6:0] == OPC_JAL);
        is_cond = 1'b0;
        if (insn[6:0] == OPC_BRANCH) begin
            unique case (f3)
                3'b010, 3'b011: is_cond = 1'b0;
                default:        is_cond = 1'b1;
            endcase
        end
    end

    assign jump_tgt = pc + imm_j;
    assign cond_tgt = pc + imm_b;

endmodule

// File: rtl/nxpc_bht.sv
`timescale 1ns/1ps
module nxpc_bht
    import nxpc_pkg::*;
#(
    parameter int IDX_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    output ctr_state_e          rd_ctr,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic                wr_taken
);

    localparam int ENTRIES = 1 << IDX_BITS;

    ctr_state_e ctr_q [ENTRIES];
    ctr_state_e wr_next;

    // Output process: read port and the trained value of the written entry.
    always_comb begin
        rd_ctr  = ctr_q[rd_idx];
        wr_next = ctr_step(ctr_q[wr_idx], wr_taken);
    end

    // State register process, one counter per entry.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctr_q[e] <= WEAK_NT;
            end else if (wr_en && (wr_idx == IDX_BITS'(e))) begin
                ctr_q[e] <= wr_next;
            end
        end
    end

endmodule

// File: rtl/nxpc_corrector.sv
`timescale 1ns/1ps
module nxpc_corrector
    import nxpc_pkg::*;
#(
    parameter int IDX_BITS = 6
) (
    input  logic                wb_valid,
    input  logic [XLEN-1:0]     wb_pc,
    input  logic                wb_taken,
    input  logic                wb_pred_taken,
    input  logic [XLEN-1:0]     wb_target,
    output logic                flush,
    output logic [XLEN-1:0]     flush_pc,
    output logic                upd_en,
    output logic [IDX_BITS-1:0] upd_idx,
    output logic                upd_taken
);

    always_comb begin
        upd_en    = wb_valid;
        upd_idx   = wb_pc[IDX_BITS+1:2];
        upd_taken = wb_taken;
        flush     = wb_valid && (wb_taken != wb_pred_taken);
        flush_pc  = wb_taken ? wb_target : (wb_pc + XLEN'(4));
    end

endmodule

// File: rtl/fetch_nextpc_predictor.sv
`timescale 1ns/1ps
module fetch_nextpc_predictor
    import nxpc_pkg::*;
#(
    parameter int IDX_BITS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_pc,
    input  logic [31:0] fetch_insn,
    output logic        pred_taken,
    output logic [31:0] pred_target,
    output logic [31:0] next_pc,
    input  logic        wb_valid,
    input  logic [31:0] wb_pc,
    input  logic        wb_taken,
    input  logic        wb_pred_taken,
    input  logic [31:0] wb_target,
    output logic        flush,
    output logic [31:0] flush_pc
);

    logic                is_jump;
    logic                is_cond;
    logic [XLEN-1:0]     jump_tgt;
    logic [XLEN-1:0]     cond_tgt;
    logic [XLEN-1:0]     seq_pc;
    ctr_state_e          cur_ctr;
    logic                upd_en;
    logic [IDX_BITS-1:0] upd_idx;
    logic                upd_taken;
    pc_sel_e             sel;

    nxpc_predecode u_decode (
        .pc       (fetch_pc),
        .insn     (fetch_insn),
        .is_jump  (is_jump),
        .is_cond  (is_cond),
        .jump_tgt (jump_tgt),
        .cond_tgt (cond_tgt)
    );

    nxpc_bht #(.IDX_BITS(IDX_BITS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_pc[IDX_BITS+1:2]),
        .rd_ctr   (cur_ctr),
        .wr_en    (upd_en),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    nxpc_corrector #(.IDX_BITS(IDX_BITS)) u_correct (
        .wb_valid      (wb_valid),
        .wb_pc         (wb_pc),
        .wb_taken      (wb_taken),
        .wb_pred_taken (wb_pred_taken),
        .wb_target     (wb_target),
        .flush         (flush),
        .flush_pc      (flush_pc),
        .upd_en        (upd_en),
        .upd_idx       (upd_idx),
        .upd_taken     (upd_taken)
    );

    assign seq_pc = fetch_pc + XLEN'(4);

    // Selection of the next-PC source, highest priority first.
    always_comb begin
        if (flush)
            sel = SEL_FLUSH;
        else if (fetch_valid && is_jump)
            sel = SEL_JUMP;
        else if (fetch_valid && is_cond && ctr_says_taken(cur_ctr))
            sel = SEL_BRANCH;
        else
            sel = SEL_SEQ;
    end

    // Prediction outputs that travel with the instruction.
    always_comb begin
        pred_taken  = 1'b0;
        pred_target = seq_pc;
        if (fetch_valid && is_jump) begin
            pred_taken  = 1'b1;
            pred_target = jump_tgt;
        end else if (fetch_valid && is_cond && ctr_says_taken(cur_ctr)) begin
            pred_taken  = 1'b1;
            pred_target = cond_tgt;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLUSH:  next_pc = flush_pc;
            SEL_JUMP:   next_pc = jump_tgt;
            SEL_BRANCH: next_pc = cond_tgt;
            SEL_SEQ:    next_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/nxpc_checker.sv
`timescale 1ns/1ps
module nxpc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_valid,
    input logic [31:0] fetch_pc,
    input logic [6:0]  fetch_op,
    input logic        pred_taken,
    input logic [31:0] pred_target,
    input logic [31:0] next_pc,
    input logic        wb_valid,
    input logic [31:0] wb_pc,
    input logic        wb_taken,
    input logic        wb_pred_taken,
    input logic [31:0] wb_target,
    input logic        flush,
    input logic [31:0] flush_pc
);

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (next_pc == flush_pc));

    assert_follow_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (next_pc == pred_target));

    assert_flush_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && (wb_taken != wb_pred_taken)) |-> flush);

    assert_flush_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (flush_pc == (wb_taken ? wb_target : wb_pc + 32'd4)));

    assert_no_spurious_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && (wb_taken != wb_pred_taken)) |-> !flush);

    assert_jump_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_op == 7'b1101111) |-> pred_taken);

    assert_idle_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (!pred_taken && pred_target == fetch_pc + 32'd4));

endmodule

bind fetch_nextpc_predictor nxpc_checker u_nxpc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .fetch_pc      (fetch_pc),
    .fetch_op      (fetch_insn[6:0]),
    .pred_taken    (pred_taken),
    .pred_target   (pred_target),
    .next_pc       (next_pc),
    .wb_valid      (wb_valid),
    .wb_pc         (wb_pc),
    .wb_taken      (wb_taken),
    .wb_pred_taken (wb_pred_taken),
    .wb_target     (wb_target),
    .flush         (flush),
    .flush_pc      (flush_pc)
);

// File: tb/test_fetch_nextpc_predictor.sv
`timescale 1ns/1ps
module test_fetch_nextpc_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] fetch_insn = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic [31:0] next_pc;
    logic        wb_valid = 1'b0;
    logic [31:0] wb_pc = '0;
    logic        wb_taken = 1'b0;
    logic        wb_pred_taken = 1'b0;
    logic [31:0] wb_target = '0;
    logic        flush;
    logic [31:0] flush_pc;

    int n_chk = 0;
    int n_fail = 0;
    int model_ctr [64];

    always #4 clk = ~clk;

    fetch_nextpc_predictor i_fetch_nextpc_predictor (.*);

    function automatic logic [31:0] enc_jal(input int off);
        logic [20:0] o = 21'(off);
        return {o[20], o[10:1], o[11], o[19:12], 5'd1, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_br(input logic [2:0] f3, input int off);
        logic [12:0] o = 13'(off);
        return {o[12], o[10:5], 5'd7, 5'd6, f3, o[4:1], o[11], 7'b1100011};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // kind: 0 = other word, 1 = jump-and-link, 2 = conditional branch
    task automatic step(input string tag, input logic fv, input logic [31:0] pc,
                        input logic [31:0] insn, input int kind, input int off,
                        input logic wv, input logic [31:0] wpc, input logic wt,
                        input logic wpt, input logic [31:0] wtgt);
        logic        e_pt;
        logic [31:0] e_tgt;
        logic        e_fl;
        logic [31:0] e_fpc;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; fetch_insn = insn;
        wb_valid = wv; wb_pc = wpc; wb_taken = wt; wb_pred_taken = wpt; wb_target = wtgt;
        e_pt = 1'b0;
        e_tgt = pc + 32'd4;
        if (fv && kind == 1) begin
            e_pt = 1'b1; e_tgt = pc + 32'(off);
        end else if (fv && kind == 2 && model_ctr[pc[7:2]] >= 2) begin
            e_pt = 1'b1; e_tgt = pc + 32'(off);
        end
        e_fl  = wv && (wt != wpt);
        e_fpc = wt ? wtgt : wpc + 32'd4;
        #2;
        chk(tag, "pred_taken", 32'(pred_taken), 32'(e_pt));
        chk(tag, "pred_target", pred_target, e_tgt);
        chk(tag, "flush", 32'(flush), 32'(e_fl));
        if (e_fl) chk(tag, "flush_pc", flush_pc, e_fpc);
        chk(tag, "next_pc", next_pc, e_fl ? e_fpc : e_tgt);
        @(posedge clk);
        if (wv) begin
            if (wt && model_ctr[wpc[7:2]] < 3) model_ctr[wpc[7:2]]++;
            else if (!wt && model_ctr[wpc[7:2]] > 0) model_ctr[wpc[7:2]]--;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model_ctr[i] = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: untrained branches fall through
        step("R1", 1, 32'h100, enc_br(3'b000, 16), 2, 16, 0, 0, 0, 0, 0);
        step("R1", 1, 32'h2FC, enc_br(3'b111, -64), 2, -64, 0, 0, 0, 0, 0);

        // R2: jumps always redirect
        step("R2", 1, 32'h200, enc_jal(2048), 1, 2048, 0, 0, 0, 0, 0);
        step("R2", 1, 32'h200, enc_jal(-12), 1, -12, 0, 0, 0, 0, 0);
        step("R2", 1, 32'h0010_0000, enc_jal(-1048576), 1, -1048576, 0, 0, 0, 0, 0);

        // R4: not a predictable word, or no valid fetch
        step("R4", 0, 32'h300, enc_jal(64), 0, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 32'h300, 32'h0050_0093, 0, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 32'h304, enc_br(3'b010, 8), 0, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 32'h308, enc_br(3'b011, 8), 0, 0, 0, 0, 0, 0, 0);

        // R5/R7: train entry 16 (pc 0x40); first report is a miss -> flush to target
        step("R7", 1, 32'h500, 32'h13, 0, 0, 1, 32'h40, 1, 0, 32'h80);
        step("R3", 1, 32'h40, enc_br(3'b001, 64), 2, 64, 1, 32'h40, 1, 1, 32'h80);
        step("R5", 1, 32'h40, enc_br(3'b100, 64), 2, 64, 1, 32'h40, 1, 1, 32'h80);
        for (int k = 0; k < 8; k++) begin
            logic [2:0] f3s [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
            if (k < 6) step("R3", 1, 32'h40, enc_br(f3s[k], -32), 2, -32, 0, 0, 0, 0, 0);
        end
        // R7: mispredicted taken -> flush to pc+4; saturated counter drops only to 10
        step("R7", 1, 32'h40, enc_br(3'b000, 8), 2, 8, 1, 32'h40, 0, 1, 32'h80);
        step("R5", 1, 32'h40, enc_br(3'b000, 8), 2, 8, 1, 32'h40, 0, 1, 32'h80);
        step("R5", 1, 32'h40, enc_br(3'b000, 8), 2, 8, 1, 32'h40, 0, 0, 32'h80);
        step("R5", 1, 32'h40, enc_br(3'b000, 8), 2, 8, 1, 32'h40, 0, 0, 32'h80);
        step("R5", 1, 32'h40, enc_br(3'b000, 8), 2, 8, 1, 32'h40, 1, 0, 32'h80);
        step("R5", 1, 32'h40, enc_br(3'b000, 8), 2, 8, 0, 32'h40, 1, 0, 32'h80);

        // R6: alias 0x140 shares index 16; 0x44 uses its own entry
        step("R6", 1, 32'h140, enc_br(3'b101, 12), 2, 12, 1, 32'h140, 1, 1, 32'h180);
        step("R6", 1, 32'h40, enc_br(3'b101, 12), 2, 12, 1, 32'h40, 1, 1, 32'h180);
        step("R6", 1, 32'h140, enc_br(3'b101, 12), 2, 12, 0, 0, 0, 0, 0);
        step("R6", 1, 32'h44, enc_br(3'b101, 12), 2, 12, 0, 0, 0, 0, 0);

        // R8: flush overrides a jump and a trained taken branch in the same cycle
        step("R8", 1, 32'h600, enc_jal(256), 1, 256, 1, 32'h900, 1, 0, 32'h940);
        step("R8", 1, 32'h40, enc_br(3'b000, 24), 2, 24, 1, 32'h904, 0, 1, 32'h980);

        // R9: fetch reads entry 20 (pc 0x50) while it is trained
        step("R9", 1, 32'h50, enc_br(3'b110, 40), 2, 40, 1, 32'h50, 1, 1, 32'h78);
        step("R9", 1, 32'h50, enc_br(3'b110, 40), 2, 40, 0, 0, 0, 0, 0);

        // R10: matching outcomes never flush
        step("R10", 1, 32'h50, enc_br(3'b110, 40), 2, 40, 1, 32'h50, 1, 1, 32'h78);
        step("R10", 1, 32'h54, 32'h13, 0, 0, 1, 32'h54, 0, 0, 32'h99C);

        // Mixed random traffic in a small aliasing window
        for (int n = 0; n < 600; n++) begin
            int          kind = $urandom_range(0, 2);
            int          off  = (kind == 1) ? (int'($urandom_range(0, 4095)) - 2048) * 2
                                            : (int'($urandom_range(0, 2047)) - 1024) * 2;
            logic [31:0] pc   = 32'h1000 + 32'($urandom_range(0, 127)) * 4;
            logic [31:0] wpc  = 32'h1000 + 32'($urandom_range(0, 127)) * 4;
            logic [31:0] w;
            logic [2:0]  f3s [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
            if (kind == 1) w = enc_jal(off);
            else if (kind == 2) w = enc_br(f3s[$urandom_range(0, 5)], off);
            else w = {25'($urandom), 7'b0010011};
            step("R3", 1'($urandom_range(0, 7) != 0), pc, w, kind, off,
                 1'($urandom), wpc, 1'($urandom), 1'($urandom), 32'($urandom) & ~32'h1);
        end

        summary();
        $finish;
    end

endmodule